// File: doc/BRIEF.md
# Prioritized Interrupt Claim Arbiter

This block gathers level-sensitive interrupt request lines from a parameterized set of sources and arbitrates among them for a few target contexts. Each context is typically one processor privilege level. The block tracks four things: which sources are waiting, which have been taken by a handler, a 3-bit priority per source, and, for each context, an enable mask and a threshold. Each context gets a notification level. The level is high while that context has at least one source that is waiting, not taken, enabled, and above its threshold.

A handler takes a source with a claim strobe for a context. One cycle later the block returns the winning source number, or zero when nothing qualifies, and marks the winner as taken. When service is done, the handler writes the source number to the completion port, which releases the source. Configuration enters through three simple write ports: source priority, context enable mask, and context threshold. Source number 0 is reserved for "no interrupt" and never takes part.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is eligible for a context only when it is waiting, not taken, and its bit in that context's enable mask is 1. Each context uses only its own mask.
- R2: An eligible source counts only if its priority is strictly greater than the context threshold. A priority equal to the threshold never raises notify and never wins a claim.
- R3: Among eligible sources with equal highest priority, the lowest source number wins.
- R4: Source number 0 never takes part. A claim with no qualifying source returns 0 and changes neither the waiting nor the taken state.
- R5: `claim_valid` is high exactly one cycle after `claim_req`, with `claim_id` holding the winner. A non-zero winner has its waiting bit cleared and its taken bit set at that same edge.
- R6: A completion whose `cmpl_id` is below NUM_SRC clears that source's taken bit at the next edge. A larger `cmpl_id` is ignored.
- R7: `notify[c]` is high exactly when context c has at least one qualifying source. It follows every change of inputs, claims, completions and configuration on the next edge.
- R8: A priority write keeps only the low 3 bits of `prio_wdata`. For example, 8'hFB stores 3.
- R9: A source's waiting bit is set at the edge where its request input is first seen high, and cleared at the edge where it is first seen low. A request held high after a claim does not set the bit again.
- R10: After reset all priorities, enable masks, thresholds, waiting bits and taken bits are 0. No context is notified, and a claim returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Level request per source (bit 0 unused) |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | ID_W | Source number for the priority write |
| prio_wdata | input | WDATA_W | Priority value (low 3 bits kept) |
| en_we | input | 1 | Enable mask write strobe |
| en_ctx | input | CTX_W | Context for the enable write |
| en_wdata | input | NUM_SRC | New enable mask |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTX_W | Context for the threshold write |
| thr_wdata | input | 3 | New threshold |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CTX_W | Claiming context |
| claim_valid | output | 1 | Claim result valid |
| claim_id | output | ID_W | Claimed source number, 0 when none |
| cmpl_req | input | 1 | Completion strobe |
| cmpl_id | input | CIDX_W | Source number being released |
| notify | output | NUM_CTX | Per-context notification level |

## Verification
Five properties are checked on every cycle:
- the one-cycle claim timing;
- that a non-zero claim result is marked taken;
- that a claim returns non-zero exactly when the claiming context was notified;
- that in-range completions release the source and out-of-range ones leave the taken set untouched;
- that source 0 is never taken.

Three behaviours can only be shown by the bench's scenarios, where its reference model predicts every cycle:
- the strict threshold comparison;
- the tie break toward low numbers;
- that a held request does not set its waiting bit again after a claim.

The same applies to truncation of priority writes and separation between contexts.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  // keep only the low priority bits of a written value
  function automatic prio_t keep_low(input logic [31:0] v);
    return v[PRIO_W-1:0];
  endfunction

  // strict comparison used for threshold and for replacing the current best
  function automatic logic outranks(input prio_t cand, input prio_t ref_p);
    return cand > ref_p;
  endfunction

  // completion identifier range check
  function automatic logic id_in_range(input logic [31:0] id, input int n);
    return id < 32'(n);
  endfunction
endpackage

// File: rtl/irq_arb_cfg.sv
module irq_arb_cfg
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int WDATA_W = 8,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              prio_we,
  input  logic [ID_W-1:0]                   prio_sel,
  input  logic [WDATA_W-1:0]                prio_wdata,
  input  logic                              en_we,
  input  logic [CTX_W-1:0]                  en_ctx,
  input  logic [NUM_SRC-1:0]                en_wdata,
  input  logic                              thr_we,
  input  logic [CTX_W-1:0]                  thr_ctx,
  input  prio_t                             thr_wdata,
  output prio_t [NUM_SRC-1:0]               prio_o,
  output logic  [NUM_CTX-1:0][NUM_SRC-1:0]  en_o,
  output prio_t [NUM_CTX-1:0]               thr_o
);
  prio_t [NUM_SRC-1:0]              prio_q;
  logic  [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  prio_t [NUM_CTX-1:0]              thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (prio_we) begin
      prio_q[prio_sel] <= keep_low(32'(prio_wdata));
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end else begin
        if (en_we && (32'(en_ctx) == c))
          en_q[c] <= en_wdata;
        if (thr_we && (32'(thr_ctx) == c))
          thr_q[c] <= thr_wdata;
      end
    end
  end

  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign thr_o  = thr_q;
endmodule

// File: rtl/irq_arb_track.sv
module irq_arb_track #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] take_set,
  input  logic [NUM_SRC-1:0] release_clr,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] claimed_o
);
  logic [NUM_SRC-1:0] req_q, pending_q, claimed_q;
  logic [NUM_SRC-1:0] rise_w, fall_w;

  assign rise_w = src_req & ~req_q;
  assign fall_w = ~src_req & req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= '0;
      pending_q <= '0;
      claimed_q <= '0;
    end else begin
      req_q     <= src_req;
      // claim clears first; a new input edge is applied on top of it
      pending_q <= ((pending_q & ~take_set) | rise_w) & ~fall_w;
      claimed_q <= (claimed_q & ~release_clr) | take_set;
    end
  end

  assign pending_o = pending_q;
  assign claimed_o = claimed_q;
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic  [NUM_SRC-1:0] cand,
  input  prio_t [NUM_SRC-1:0] prio,
  input  prio_t               thr,
  output logic  [ID_W-1:0]    best_id,
  output logic                any
);
  prio_t best_p;

  always_comb begin
    best_id = '0;
    best_p  = thr;
    // ascending scan, replace only on strictly higher priority
    for (int i = 1; i < NUM_SRC; i++) begin
      if (cand[i] && outranks(prio[i], best_p)) begin
        best_id = ID_W'(i);
        best_p  = prio[i];
      end
    end
  end

  assign any = (best_id != '0);
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int WDATA_W = 8,
  parameter int CIDX_W  = 8,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_req,
  input  logic                 prio_we,
  input  logic [ID_W-1:0]      prio_sel,
  input  logic [WDATA_W-1:0]   prio_wdata,
  input  logic                 en_we,
  input  logic [CTX_W-1:0]     en_ctx,
  input  logic [NUM_SRC-1:0]   en_wdata,
  input  logic                 thr_we,
  input  logic [CTX_W-1:0]     thr_ctx,
  input  logic [2:0]           thr_wdata,
  input  logic                 claim_req,
  input  logic [CTX_W-1:0]     claim_ctx,
  output logic                 claim_valid,
  output logic [ID_W-1:0]      claim_id,
  input  logic                 cmpl_req,
  input  logic [CIDX_W-1:0]    cmpl_id,
  output logic [NUM_CTX-1:0]   notify
);
  prio_t [NUM_SRC-1:0]              prio_w;
  logic  [NUM_CTX-1:0][NUM_SRC-1:0] en_w;
  prio_t [NUM_CTX-1:0]              thr_w;
  logic  [NUM_SRC-1:0]              pending_w, claimed_w;
  logic  [NUM_SRC-1:0]              take_set_w, release_clr_w;
  logic  [NUM_CTX-1:0][ID_W-1:0]    best_w;
  logic  [NUM_CTX-1:0]              any_w;
  logic  [ID_W-1:0]                 winner_w;
  logic                             cmpl_ok_w;

  irq_arb_cfg #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .WDATA_W(WDATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .en_we(en_we), .en_ctx(en_ctx), .en_wdata(en_wdata),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_wdata(prio_t'(thr_wdata)),
    .prio_o(prio_w), .en_o(en_w), .thr_o(thr_w)
  );

  irq_arb_track #(.NUM_SRC(NUM_SRC)) track_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .take_set(take_set_w), .release_clr(release_clr_w),
    .pending_o(pending_w), .claimed_o(claimed_w)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_pick
    logic [NUM_SRC-1:0] cand_w;
    // source 0 is reserved and masked out here
    assign cand_w = pending_w & ~claimed_w & en_w[c] & {{(NUM_SRC-1){1'b1}}, 1'b0};
    irq_arb_pick #(.NUM_SRC(NUM_SRC)) pick_i (
      .cand(cand_w), .prio(prio_w), .thr(thr_w[c]),
      .best_id(best_w[c]), .any(any_w[c])
    );
  end

  assign notify    = any_w;
  assign winner_w  = claim_req ? best_w[claim_ctx] : '0;
  assign cmpl_ok_w = cmpl_req && id_in_range(32'(cmpl_id), NUM_SRC);

  always_comb begin
    take_set_w    = '0;
    release_clr_w = '0;
    if (winner_w != '0)
      take_set_w[winner_w] = 1'b1;
    if (cmpl_ok_w)
      release_clr_w[cmpl_id[ID_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_valid <= 1'b0;
      claim_id    <= '0;
    end else begin
      claim_valid <= claim_req;
      claim_id    <= winner_w;
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int CIDX_W  = 8,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               claim_req,
  input logic [CTX_W-1:0]   claim_ctx,
  input logic               claim_valid,
  input logic [ID_W-1:0]    claim_id,
  input logic               cmpl_req,
  input logic [CIDX_W-1:0]  cmpl_id,
  input logic [NUM_CTX-1:0] notify,
  input logic [NUM_SRC-1:0] claimed_w
);
  a_r5_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    claim_req |=> claim_valid);
  a_r5_valid_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_req |=> !claim_valid);
  a_r5_winner_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_valid && claim_id != '0) |-> claimed_w[claim_id]);
  a_r7_notified_claim_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && notify[claim_ctx]) |=> (claim_id != '0));
  a_r4_quiet_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && !notify[claim_ctx]) |=> (claim_id == '0));
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && !claim_req && 32'(cmpl_id) < NUM_SRC)
      |=> !claimed_w[$past(cmpl_id[ID_W-1:0])]);
  a_r6_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && !claim_req && 32'(cmpl_id) >= NUM_SRC)
      |=> (claimed_w == $past(claimed_w)));
  a_r4_zero_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    !claimed_w[0]);
endmodule

bind irq_claim_arbiter irq_arb_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .CIDX_W(CIDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .claim_ctx(claim_ctx),
  .claim_valid(claim_valid), .claim_id(claim_id), .cmpl_req(cmpl_req),
  .cmpl_id(cmpl_id), .notify(notify), .claimed_w(claimed_w)
);

// File: tb/irq_claim_arbiter_tb.sv
module irq_claim_arbiter_tb_top;
  localparam int NS = 32;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic          prio_we = 1'b0;
  logic [4:0]    prio_sel = '0;
  logic [7:0]    prio_wdata = '0;
  logic          en_we = 1'b0;
  logic [0:0]    en_ctx = '0;
  logic [NS-1:0] en_wdata = '0;
  logic          thr_we = 1'b0;
  logic [0:0]    thr_ctx = '0;
  logic [2:0]    thr_wdata = '0;
  logic          claim_req = 1'b0;
  logic [0:0]    claim_ctx = '0;
  logic          claim_valid;
  logic [4:0]    claim_id;
  logic          cmpl_req = 1'b0;
  logic [7:0]    cmpl_id = '0;
  logic [NC-1:0] notify;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_pend[NS], m_clmd[NS], m_req[NS], m_prio[NS];
  int m_en[NC][NS];
  int m_thr[NC];

  always #2 clk = ~clk;

  irq_claim_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .en_we(en_we), .en_ctx(en_ctx), .en_wdata(en_wdata),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_wdata(thr_wdata),
    .claim_req(claim_req), .claim_ctx(claim_ctx),
    .claim_valid(claim_valid), .claim_id(claim_id),
    .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .notify(notify)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_notify(input int c);
    for (int i = 1; i < NS; i++)
      if (m_pend[i] != 0 && m_clmd[i] == 0 && m_en[c][i] != 0 && m_prio[i] > m_thr[c])
        return 1;
    return 0;
  endfunction

  // one clock: predict, advance, compare
  task automatic step(input string tag);
    int win = 0;
    int best;
    int exp_valid;
    if (claim_req) begin
      best = m_thr[claim_ctx];
      for (int i = 1; i < NS; i++)
        if (m_pend[i] != 0 && m_clmd[i] == 0 && m_en[claim_ctx][i] != 0 && m_prio[i] > best) begin
          win = i;
          best = m_prio[i];
        end
    end
    exp_valid = claim_req ? 1 : 0;
    for (int i = 0; i < NS; i++) begin
      if (win == i && win != 0) m_pend[i] = 0;
      if (src_req[i] && m_req[i] == 0) m_pend[i] = 1;
      if (!src_req[i] && m_req[i] != 0) m_pend[i] = 0;
      m_req[i] = src_req[i] ? 1 : 0;
    end
    if (cmpl_req && cmpl_id < NS) m_clmd[cmpl_id] = 0;
    if (win != 0) m_clmd[win] = 1;
    if (prio_we) m_prio[prio_sel] = prio_wdata % 8;
    if (en_we) for (int i = 0; i < NS; i++) m_en[en_ctx][i] = en_wdata[i] ? 1 : 0;
    if (thr_we) m_thr[thr_ctx] = thr_wdata;
    @(posedge clk);
    #1;
    chk(claim_valid == exp_valid[0], tag, "claim_valid", claim_valid, exp_valid);
    if (exp_valid != 0)
      chk(claim_id == win[4:0], tag, "claim_id", claim_id, win);
    for (int c = 0; c < NC; c++)
      chk(notify[c] == model_notify(c)[0], tag, $sformatf("notify[%0d]", c), notify[c], model_notify(c));
    prio_we = 0; en_we = 0; thr_we = 0; claim_req = 0; cmpl_req = 0;
  endtask

  task automatic wr_prio(input int id, input int v, input string tag);
    prio_we = 1; prio_sel = id[4:0]; prio_wdata = v[7:0]; step(tag);
  endtask
  task automatic wr_en(input int c, input logic [NS-1:0] m, input string tag);
    en_we = 1; en_ctx = c[0:0]; en_wdata = m; step(tag);
  endtask
  task automatic wr_thr(input int c, input int v, input string tag);
    thr_we = 1; thr_ctx = c[0:0]; thr_wdata = v[2:0]; step(tag);
  endtask
  task automatic do_claim(input int c, input string tag);
    claim_req = 1; claim_ctx = c[0:0]; step(tag);
  endtask
  task automatic do_cmpl(input int id, input string tag);
    cmpl_req = 1; cmpl_id = id[7:0]; step(tag);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_pend[i] = 0; m_clmd[i] = 0; m_req[i] = 0; m_prio[i] = 0;
      for (int c = 0; c < NC; c++) m_en[c][i] = 0;
    end
    for (int c = 0; c < NC; c++) m_thr[c] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(notify == '0, "R10", "notify after reset", notify, 0);
    chk(claim_valid == 1'b0, "R10", "claim_valid after reset", claim_valid, 0);
    do_claim(0, "R10");                             // nothing configured: 0
    src_req[1] = 1; src_req[3] = 1; src_req[5] = 1;
    step("R9");
    wr_en(0, '1, "R10");                            // priorities still 0
    wr_prio(1, 1, "R7");
    wr_prio(3, 2, "R7");
    wr_prio(5, 2, "R7");
    do_claim(0, "R3");                              // tie 3/5 -> 3
    do_claim(0, "R1");                              // 3 taken -> 5
    do_claim(0, "R5");                              // -> 1
    do_claim(0, "R4");                              // none -> 0
    do_cmpl(3, "R9");                               // held request, no new edge
    src_req[3] = 0; step("R9");
    src_req[3] = 1; step("R9");                     // new edge sets waiting
    wr_thr(0, 2, "R2");                             // prio 2 == thr -> quiet
    do_claim(0, "R2");
    wr_prio(3, 8'hFB, "R8");                        // keeps 3
    do_claim(0, "R8");
    src_req[3] = 0; step("R1");
    src_req[3] = 1; step("R1");                     // waiting but taken
    do_cmpl(40, "R6");                              // out of range ignored
    do_cmpl(32, "R6");
    do_cmpl(3, "R6");                               // release -> notify
    wr_en(1, 32'h0000_0080, "R1");
    wr_prio(7, 4, "R1");
    src_req[7] = 1; step("R1");
    do_claim(1, "R1");
    wr_en(1, 32'h0000_0081, "R4");
    src_req[0] = 1; step("R4");
    wr_prio(0, 7, "R4");
    do_claim(1, "R4");                              // source 0 never wins
    cmpl_req = 1; cmpl_id = 8'd7; claim_req = 1; claim_ctx = 1'b0;
    step("R5");                                     // claim and release together
    do_claim(1, "R6");
    src_req = '0; step("R9");
    step("R7");
    rst_n = 0; step("R10");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule